// File: doc/BRIEF.md
# Polled Byte Copy Engine

This block moves a run of bytes from a peripheral into system memory without the processor touching each byte. Software loads a length and a destination address into the register file and then sets the go bit. The engine then loops. It reads the peripheral's status word until the ready flag is set. It fetches one byte from the peripheral's data word and writes that byte to memory through a request/grant handshake. It then steps the address up by one and the remaining length down by one.

When the last byte has been accepted by memory, the engine returns to idle and raises a sticky completion flag. An interrupt line can mirror that flag, so the processor is disturbed once per block and not once per byte. Fetching the data word clears the peripheral's ready flag, so the engine polls again before every byte.

Top module: `byte_mover`

## Requirements
- R1: After reset, busy, done, irq, mem_req and dev_rd are all 0, and the control (index 2) and status (index 3) registers read as 0.
- R2: A write to the control register (index 2) with bit 0 (go) set, made while idle with a nonzero length, starts a transfer. Status bit 0 (busy) reads 1 in the cycle after that write.
- R3: Before each byte the engine reads the peripheral status word (dev_rd=1, dev_sel=0) and keeps polling while its bit 0 is 0. It reads the data word (dev_rd=1, dev_sel=1) only in the cycle after it has seen bit 0 equal to 1, and it does so exactly once per byte.
- R4: Byte k of the block, taken from bits 7:0 of the data word, is written to address base+k. The transfer makes exactly as many memory writes as the programmed length (index 0), starting at the programmed base (index 1).
- R5: While mem_req is high and mem_gnt is low, mem_req, mem_addr and mem_wdata hold steady. After a cycle with both high, mem_req is low in the next cycle.
- R6: After the last write is granted, busy falls and status bit 1 (done) is set.
- R7: Go with a length of 0 sets done at once. It causes no memory or peripheral access, and busy is never set.
- R8: A go write made while busy is ignored. Writes to the length or base register during a transfer change the values read back, but they do not change the transfer in flight.
- R9: Done stays set until software writes 1 to status bit 1. A write of 0 to that bit leaves it set.
- R10: irq is high exactly when done is set and control bit 1 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 2 | Register index for write (0 length, 1 base, 2 control, 3 status) |
| reg_wr_data | input | REG_W | Register write data |
| reg_rd_idx | input | 2 | Register index for read |
| reg_rd_data | output | REG_W | Register read data (combinational) |
| dev_rd | output | 1 | Peripheral read strobe |
| dev_sel | output | 1 | Peripheral word select: 0 status, 1 data |
| dev_rdata | input | DEV_W | Peripheral read data, same cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory write grant |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after a slow peripheral whose ready flag drops for several cycles after every fetch. An engine that fetched without a fresh poll would copy stale bytes and read the data word too often. It pairs this with a memory that withholds grant for several cycles. A design that advanced without waiting for grant would write fewer bytes, or write them to skipped addresses.

A zero-length go is checked for an immediate done with no bus traffic. A design that ran the loop would wrap the length and write a very long block. A second go and new length and base writes issued mid-transfer must leave the write log untouched, which catches a design that reloads its working copies. The write-0 and write-1 cases on the done flag, and the done flag with the enable both set and clear, show whether the flag is truly sticky and whether irq is gated by the enable.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_FETCH = 2'd2,
    ST_STORE = 2'd3
  } mover_state_e;

  localparam logic [1:0] IDX_LEN  = 2'd0;
  localparam logic [1:0] IDX_BASE = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;
  localparam int unsigned DEV_RDY_BIT   = 0;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/bm_regs.sv
module bm_regs
  import bm_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_idx,
  output logic [REG_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              done_set,
  output logic [CNT_W-1:0]  prog_len,
  output logic [ADDR_W-1:0] prog_base,
  output logic              ie,
  output logic              done,
  output logic              go_req
);

  logic [CNT_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic              ie_q;
  logic              done_q;

  logic wr_len, wr_base, wr_ctrl, wr_stat;
  logic done_clr;

  assign wr_len   = wr_en && (wr_idx == IDX_LEN);
  assign wr_base  = wr_en && (wr_idx == IDX_BASE);
  assign wr_ctrl  = wr_en && (wr_idx == IDX_CTRL);
  assign wr_stat  = wr_en && (wr_idx == IDX_STAT);
  assign done_clr = wr_stat && wr_data[STAT_DONE_BIT];
  assign go_req   = wr_ctrl && wr_data[CTRL_GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_len)  len_q  <= wr_data[CNT_W-1:0];
      if (wr_base) base_q <= wr_data[ADDR_W-1:0];
      if (wr_ctrl) ie_q   <= wr_data[CTRL_IE_BIT];
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IDX_LEN:  rd_data[CNT_W-1:0]  = len_q;
      IDX_BASE: rd_data[ADDR_W-1:0] = base_q;
      IDX_CTRL: rd_data[CTRL_IE_BIT] = ie_q;
      default: begin
        rd_data[STAT_BUSY_BIT] = busy;
        rd_data[STAT_DONE_BIT] = done_q;
      end
    endcase
  end

  assign prog_len  = len_q;
  assign prog_base = base_q;
  assign ie        = ie_q;
  assign done      = done_q;

endmodule

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic [CNT_W-1:0]  prog_len,
  input  logic [ADDR_W-1:0] prog_base,
  input  logic              dev_ready,
  input  logic [BYTE_W-1:0] dev_byte,
  input  logic              mem_gnt,
  output logic              dev_rd,
  output logic              dev_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done_set,
  output logic              go_accept,
  output logic              go_zero,
  output logic              byte_ack
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] len_step(input logic [CNT_W-1:0] n);
    return n - CNT_W'(1);
  endfunction

  mover_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] byte_q;
  logic              idle;
  logic              last_byte;

  assign idle      = (state_q == ST_IDLE);
  assign go_accept = idle && go_req && (prog_len != '0);
  assign go_zero   = idle && go_req && (prog_len == '0);
  assign byte_ack  = (state_q == ST_STORE) && mem_gnt;
  assign last_byte = (left_q == CNT_W'(1));
  assign done_set  = go_zero || (byte_ack && last_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_accept) begin
            addr_q  <= prog_base;
            left_q  <= prog_len;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (dev_ready) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          byte_q  <= dev_byte;
          state_q <= ST_STORE;
        end
        default: begin
          if (mem_gnt) begin
            addr_q  <= addr_step(addr_q);
            left_q  <= len_step(left_q);
            state_q <= last_byte ? ST_IDLE : ST_POLL;
          end
        end
      endcase
    end
  end

  assign dev_rd    = (state_q == ST_POLL) || (state_q == ST_FETCH);
  assign dev_sel   = (state_q == ST_FETCH);
  assign mem_req   = (state_q == ST_STORE);
  assign mem_addr  = addr_q;
  assign mem_wdata = byte_q;
  assign busy      = !idle;

endmodule

// File: rtl/byte_mover.sv
module byte_mover
  import bm_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_idx,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic [1:0]        reg_rd_idx,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              dev_rd,
  output logic              dev_sel,
  input  logic [DEV_W-1:0]  dev_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  output logic              irq
);

  logic [CNT_W-1:0]  prog_len_w;
  logic [ADDR_W-1:0] prog_base_w;
  logic              ie_w;
  logic              done_w;
  logic              go_req_w;
  logic              busy_w;
  logic              done_set_w;
  logic              go_accept_w;
  logic              go_zero_w;
  logic              byte_ack_w;
  logic              dev_ready_w;
  logic [BYTE_W-1:0] dev_byte_w;
  logic              dev_unused;

  assign dev_ready_w = dev_rdata[DEV_RDY_BIT];
  assign dev_byte_w  = dev_rdata[BYTE_W-1:0];
  assign dev_unused  = ^dev_rdata[DEV_W-1:BYTE_W];

  bm_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_idx    (reg_wr_idx),
    .wr_data   (reg_wr_data),
    .rd_idx    (reg_rd_idx),
    .rd_data   (reg_rd_data),
    .busy      (busy_w),
    .done_set  (done_set_w),
    .prog_len  (prog_len_w),
    .prog_base (prog_base_w),
    .ie        (ie_w),
    .done      (done_w),
    .go_req    (go_req_w)
  );

  bm_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_req    (go_req_w),
    .prog_len  (prog_len_w),
    .prog_base (prog_base_w),
    .dev_ready (dev_ready_w),
    .dev_byte  (dev_byte_w),
    .mem_gnt   (mem_gnt),
    .dev_rd    (dev_rd),
    .dev_sel   (dev_sel),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy_w),
    .done_set  (done_set_w),
    .go_accept (go_accept_w),
    .go_zero   (go_zero_w),
    .byte_ack  (byte_ack_w)
  );

  assign irq = done_w && ie_w;

endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEV_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_rd,
  input logic              dev_sel,
  input logic [DEV_W-1:0]  dev_rdata,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic              go_zero
);

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req);

  // R3
  fetch_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && dev_sel) |-> $past(dev_rd && !dev_sel && dev_rdata[0]));

  // R4
  write_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R6
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_zero |=> (done && !busy && !mem_req && !dev_rd));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

endmodule

bind byte_mover bm_chk #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_rd    (dev_rd),
  .dev_sel   (dev_sel),
  .dev_rdata (dev_rdata),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq       (irq),
  .busy      (busy_w),
  .done      (done_w),
  .go_zero   (go_zero_w)
);

// File: tb/sim_byte_mover.sv
module sim_byte_mover;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_idx = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_idx = 2'd0;
  logic [31:0] reg_rd_data;
  logic        dev_rd, dev_sel;
  logic [31:0] dev_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        irq;

  int nchk = 0;
  int nfail = 0;

  // peripheral model
  logic dev_ready = 1'b0;
  int   dev_idx = 0;
  int   dev_gap = 0;
  int   gap_cnt = 0;
  bit   fetch_pend = 0;
  int   data_reads = 0;
  int   polls_low = 0;
  int   bad_fetch = 0;

  // memory model
  int   mem_lat = 0;
  int   mem_wait = 0;
  int   nwr = 0;
  logic [31:0] log_addr [0:63];
  logic [7:0]  log_data [0:63];

  function automatic logic [7:0] dev_byte_of(input int i);
    return 8'((i * 7 + 49) & 255);
  endfunction

  assign dev_rdata = dev_sel ? {24'hC3A5F0, dev_byte_of(dev_idx)} : {31'h55, dev_ready};

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_mover u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .dev_rd(dev_rd), .dev_sel(dev_sel), .dev_rdata(dev_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (fetch_pend) begin
      fetch_pend = 0;
      dev_ready  = 1'b0;
      dev_idx    = dev_idx + 1;
      gap_cnt    = dev_gap;
    end else if (!dev_ready) begin
      if (gap_cnt == 0) dev_ready = 1'b1;
      else gap_cnt = gap_cnt - 1;
    end
    if (dev_rd && dev_sel) begin
      fetch_pend = 1;
      data_reads = data_reads + 1;
      if (!dev_ready) bad_fetch = bad_fetch + 1;
    end
    if (dev_rd && !dev_sel && !dev_ready) polls_low = polls_low + 1;
  end

  always @(negedge clk) begin
    if (mem_gnt) begin
      mem_gnt  = 1'b0;
      mem_wait = 0;
    end else if (mem_req) begin
      if (mem_wait >= mem_lat) begin
        mem_gnt = 1'b1;
        if (nwr < 64) begin
          log_addr[nwr] = mem_addr;
          log_data[nwr] = mem_wdata;
        end
        nwr = nwr + 1;
      end else begin
        mem_wait = mem_wait + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] idx, output logic [31:0] val);
    reg_rd_idx = idx;
    #1;
    val = reg_rd_data;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    reg_read(2'd3, s);
    while (s[0] && n < 5000) begin
      @(negedge clk);
      reg_read(2'd3, s);
      n++;
    end
    chk(req, 32'(n < 5000), 32'd1);
  endtask

  task automatic clear_logs();
    nwr = 0; data_reads = 0; polls_low = 0; bad_fetch = 0;
  endtask

  task automatic check_block(input string req, input int n, input logic [31:0] base, input int first);
    chk(req, 32'(nwr), 32'(n));
    for (int k = 0; k < n && k < 64; k++) begin
      chk(req, log_addr[k], base + 32'(k));
      chk(req, {24'h0, log_data[k]}, {24'h0, dev_byte_of(first + k)});
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd3, v); chk("R1 status", v, 32'h0);
    reg_read(2'd2, v); chk("R1 control", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 dev_rd", 32'(dev_rd), 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int first;
    dev_gap = 0; mem_lat = 0; clear_logs(); first = dev_idx;
    reg_write(2'd0, 32'd4);
    reg_write(2'd1, 32'h100);
    reg_write(2'd2, 32'h3);
    reg_read(2'd3, v); chk("R2 busy after go", v & 32'h1, 32'h1);
    wait_idle("R6 finishes");
    reg_read(2'd3, v); chk("R6 done set busy clear", v, 32'h2);
    check_block("R4 basic block", 4, 32'h100, first);
    chk("R3 one data read per byte", 32'(data_reads), 32'd4);
    chk("R3 no fetch without ready", 32'(bad_fetch), 32'd0);
    chk("R10 irq with enable", 32'(irq), 32'd1);
  endtask

  task automatic t_slow();
    logic [31:0] v;
    int first;
    reg_write(2'd3, 32'h2);
    dev_gap = 4; mem_lat = 3; clear_logs(); first = dev_idx;
    reg_write(2'd0, 32'd3);
    reg_write(2'd1, 32'h7F0);
    reg_write(2'd2, 32'h1);
    wait_idle("R6 slow finishes");
    check_block("R5 slow grant block", 3, 32'h7F0, first);
    chk("R3 waited on ready", 32'(polls_low > 0), 32'd1);
    chk("R3 data reads slow", 32'(data_reads), 32'd3);
    reg_read(2'd3, v); chk("R6 done slow", v, 32'h2);
    chk("R10 irq masked", 32'(irq), 32'd0);
    reg_write(2'd3, 32'h0);
    reg_read(2'd3, v); chk("R9 write 0 keeps done", v, 32'h2);
    reg_write(2'd3, 32'h2);
    reg_read(2'd3, v); chk("R9 write 1 clears done", v, 32'h0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    dev_gap = 0; mem_lat = 0; clear_logs();
    reg_write(2'd0, 32'd0);
    reg_write(2'd2, 32'h3);
    reg_read(2'd3, v); chk("R7 done at once", v, 32'h2);
    chk("R10 irq on zero length", 32'(irq), 32'd1);
    repeat (6) @(negedge clk);
    reg_read(2'd3, v); chk("R7 still idle", v, 32'h2);
    chk("R7 no memory write", 32'(nwr), 32'd0);
    chk("R7 no data read", 32'(data_reads), 32'd0);
    reg_write(2'd3, 32'h2);
    chk("R10 irq drops with done", 32'(irq), 32'd0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int first;
    dev_gap = 3; mem_lat = 1; clear_logs(); first = dev_idx;
    reg_write(2'd0, 32'd5);
    reg_write(2'd1, 32'h300);
    reg_write(2'd2, 32'h1);
    reg_write(2'd0, 32'd2);
    reg_write(2'd1, 32'h900);
    reg_write(2'd2, 32'h1);
    reg_read(2'd3, v); chk("R8 still busy", v & 32'h1, 32'h1);
    wait_idle("R8 finishes");
    repeat (4) @(negedge clk);
    check_block("R8 block unchanged", 5, 32'h300, first);
    reg_read(2'd0, v); chk("R8 length readback", v, 32'd2);
    reg_read(2'd1, v); chk("R8 base readback", v, 32'h900);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_slow();
    t_zero();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule